// File: doc/BRIEF.md
# Parallel Port Enhanced-Mode Write Sequencer

This block is the host side of an Enhanced Parallel Port (EPP 1.7) write. A host bus write, carrying a byte and a flag that selects either the data register or the address register, is turned into a peripheral-side handshake. The block drives the byte onto the parallel bus and pulls the active-low write line low. After a configurable setup gap it asserts either the data strobe or the address strobe. It then waits for the peripheral's wait line to go high.

While the handshake is open, the block holds the host bus ready line low. This stretches the host cycle until the peripheral answers. If the peripheral never answers, a counter in clock cycles ends the wait, releases the ready line and sets a sticky timeout flag. Software clears that flag by writing 1 to it. The strobe is released only after the host write strobe has gone inactive. The write line and the data bus are released a configurable number of clocks after that.

A write is started only when the port direction bit is 0. A new cycle is accepted only when the sequencer is idle and the peripheral wait line is low.

Top module: `epp_wr_ctrl`

## Requirements
- R1: With `dir_i` at 1, a rising `bus_wr_i` starts no cycle: `write_no`, both strobes and `bus_rdy_o` stay 1 and `par_data_oe_o` stays 0.
- R2: When `bus_wr_i` is sampled high after being sampled low on the previous clock, with `dir_i` at 0 and `per_wait_i` at 0, then from the next cycle `write_no` is 0, `par_data_oe_o` is 1, `bus_rdy_o` is 0 and `par_data_o` carries the byte sampled on that edge.
- R3: The selected strobe goes low exactly SETUP_CLKS cycles after `write_no` goes low. `par_data_o` stays constant from the fall of `write_no` until its rise.
- R4: `bus_addr_sel_i` = 1 selects `addr_stb_no` and 0 selects `data_stb_no`, sampled at the start of the cycle. The two strobes are never low at the same time.
- R5: While a strobe is low and the timeout has not expired, `per_wait_i` sampled high makes `bus_rdy_o` 1 from the next cycle. The strobe stays low.
- R6: Once `bus_rdy_o` is 1 with a strobe low, the strobe rises on the cycle after `bus_wr_i` is sampled low. `write_no` rises and `par_data_oe_o` falls HOLD_CLKS cycles after the strobe rises.
- R7: If `per_wait_i` stays low for TMO_CLKS cycles of strobe, `bus_rdy_o` goes back to 1 and `tmo_o` goes to 1 on the next cycle.
- R8: `tmo_o` stays 1 until a cycle in which `tmo_clr_i` is sampled high and no new timeout occurs. It then reads 0 from the next cycle.
- R9: A rising `bus_wr_i` is dropped while a cycle is in progress, or while the sequencer is idle but `per_wait_i` is high.
- R10: After reset, `write_no`, both strobes and `bus_rdy_o` are 1, and `par_data_oe_o`, `par_data_o` and `tmo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Host bus write strobe, active high |
| bus_addr_sel_i | input | 1 | 1 targets the address register, 0 targets the data register |
| bus_data_i | input | DW | Byte written by the host |
| dir_i | input | 1 | Port direction bit; 0 permits writes |
| tmo_clr_i | input | 1 | Write-1 clear of the timeout flag |
| per_wait_i | input | 1 | Peripheral wait line; high means the handshake is complete |
| par_data_o | output | DW | Parallel data bus |
| par_data_oe_o | output | 1 | Parallel data drive enable |
| write_no | output | 1 | Write line, active low |
| data_stb_no | output | 1 | Data strobe, active low |
| addr_stb_no | output | 1 | Address strobe, active low |
| bus_rdy_o | output | 1 | Host bus ready; low stretches the host cycle |
| tmo_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with SETUP_CLKS=2, HOLD_CLKS=3 and TMO_CLKS=20.

With TMO_CLKS shortened, the timeout, the sticky flag and its clear can be reached in a few dozen cycles instead of thousands. Gap lengths above one clock show that the setup and release windows are counted and not merely entered.

The peripheral response delay is varied so that completion lands both well before and exactly at the timeout boundary. A host edge is issued during the release window to confirm that it is dropped.

// File: rtl/epp_wr_pkg.sv
package epp_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STB   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_REL   = 3'd4
  } epp_st_e;
endpackage

// File: rtl/epp_wr_timer.sv
module epp_wr_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/epp_wr_status.sv
module epp_wr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R8
  AST_HOLD_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R8
endmodule

// File: rtl/epp_wr_fsm.sv
module epp_wr_fsm
  import epp_wr_pkg::*;
#(
  parameter int CW      = 8,
  parameter int SETUP_V = 1,
  parameter int TMO_V   = 1,
  parameter int HOLD_V  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          dir_i,
  input  logic          per_wait_i,
  input  logic          cnt_zero_i,
  output epp_st_e       state_o,
  output logic          cap_o,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic          dec_o,
  output logic          tmo_set_o
);
  epp_st_e st_q, st_d;
  logic    wr_prev_q;
  logic    start;

  assign start = bus_wr_i && !wr_prev_q && !dir_i && !per_wait_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wr_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      wr_prev_q <= bus_wr_i;
    end
  end

  always_comb begin
    st_d      = st_q;
    cap_o     = 1'b0;
    ld_o      = 1'b0;
    ld_val_o  = '0;
    dec_o     = 1'b0;
    tmo_set_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d     = ST_SETUP;
        cap_o    = 1'b1;
        ld_o     = 1'b1;
        ld_val_o = CW'(SETUP_V);
      end
      ST_SETUP: begin
        if (cnt_zero_i) begin
          st_d     = ST_STB;
          ld_o     = 1'b1;
          ld_val_o = CW'(TMO_V);
        end else dec_o = 1'b1;
      end
      ST_STB: begin
        if (per_wait_i) st_d = ST_HOLD;
        else if (cnt_zero_i) begin
          st_d      = ST_HOLD;
          tmo_set_o = 1'b1;
        end else dec_o = 1'b1;
      end
      ST_HOLD: if (!bus_wr_i) begin
        st_d     = ST_REL;
        ld_o     = 1'b1;
        ld_val_o = CW'(HOLD_V);
      end
      ST_REL: begin
        if (cnt_zero_i) st_d = ST_IDLE;
        else dec_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign state_o = st_q;

  AST_DIR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && dir_i) |=> st_q == ST_IDLE); // R1
  AST_WAIT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && per_wait_i) |=> st_q == ST_IDLE); // R9
  AST_ACK_ENDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STB && per_wait_i) |=> st_q == ST_HOLD); // R5
endmodule

// File: rtl/epp_wr_ctrl.sv
module epp_wr_ctrl
  import epp_wr_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SETUP_CLKS = 1,
  parameter int HOLD_CLKS  = 1,
  parameter int TMO_CLKS   = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_addr_sel_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          dir_i,
  input  logic          tmo_clr_i,
  input  logic          per_wait_i,
  output logic [DW-1:0] par_data_o,
  output logic          par_data_oe_o,
  output logic          write_no,
  output logic          data_stb_no,
  output logic          addr_stb_no,
  output logic          bus_rdy_o,
  output logic          tmo_o
);
  localparam int MAX_A = (SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS;
  localparam int MAX_C = (TMO_CLKS > MAX_A) ? TMO_CLKS : MAX_A;
  localparam int CW    = $clog2(MAX_C + 1);

  epp_st_e       st;
  logic          cap, ld, dec, cnt_zero, tmo_set;
  logic [CW-1:0] ld_val;
  logic [DW-1:0] data_q;
  logic          sel_q;
  logic          active, stb_on;

  epp_wr_fsm #(
    .CW(CW), .SETUP_V(SETUP_CLKS - 1), .TMO_V(TMO_CLKS - 1), .HOLD_V(HOLD_CLKS - 1)
  ) u_fsm (
    .clk_i, .rst_ni, .bus_wr_i, .dir_i, .per_wait_i,
    .cnt_zero_i(cnt_zero), .state_o(st), .cap_o(cap), .ld_o(ld),
    .ld_val_o(ld_val), .dec_o(dec), .tmo_set_o(tmo_set)
  );

  epp_wr_timer #(.W(CW)) u_tmr (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .dec_i(dec), .zero_o(cnt_zero)
  );

  epp_wr_status u_sts (
    .clk_i, .rst_ni, .set_i(tmo_set), .clr_i(tmo_clr_i), .flag_o(tmo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      sel_q  <= 1'b0;
    end else if (cap) begin
      data_q <= bus_data_i;
      sel_q  <= bus_addr_sel_i;
    end
  end

  assign active        = (st != ST_IDLE);
  assign stb_on        = (st == ST_STB) || (st == ST_HOLD);
  assign par_data_o    = data_q;
  assign par_data_oe_o = active;
  assign write_no      = !active;
  assign data_stb_no   = !(stb_on && !sel_q);
  assign addr_stb_no   = !(stb_on && sel_q);
  assign bus_rdy_o     = !((st == ST_SETUP) || (st == ST_STB));

  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~data_stb_no, ~addr_stb_no}) <= 1); // R4
  AST_WR_BEFORE_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_stb_no && addr_stb_no) |-> $past(!write_no)); // R3
  AST_DATA_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_no && $past(!write_no)) |-> $stable(par_data_o)); // R3
  AST_STB_AFTER_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_stb_no && addr_stb_no) |-> $past(!bus_wr_i)); // R6
  AST_WR_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(write_no) |-> $past(data_stb_no && addr_stb_no)); // R6
  AST_TMO_IN_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> $past(!(data_stb_no && addr_stb_no) && !per_wait_i)); // R7
endmodule

// File: tb/epp_wr_ctrl_bench.sv
module epp_wr_ctrl_bench;
  localparam int DW = 8, SU = 2, HD = 3, TM = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, sel = 0, dir = 0, clr = 0, pwait = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] pd;
  logic pd_oe, wr_n, ds_n, as_n, rdy, tmo;

  int total = 0, bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  epp_wr_ctrl #(.DW(DW), .SETUP_CLKS(SU), .HOLD_CLKS(HD), .TMO_CLKS(TM)) u_epp_wr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_sel_i(sel),
    .bus_data_i(din), .dir_i(dir), .tmo_clr_i(clr), .per_wait_i(pwait),
    .par_data_o(pd), .par_data_oe_o(pd_oe), .write_no(wr_n),
    .data_stb_no(ds_n), .addr_stb_no(as_n), .bus_rdy_o(rdy), .tmo_o(tmo)
  );

  // reference model: 0 idle,1 setup,2 strobe,3 hold,4 release
  int ph, rem;
  logic m_sel, m_tmo, m_prev;
  logic [DW-1:0] m_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; rem = 0; m_sel = 0; m_tmo = 0; m_prev = 0; m_dat = '0;
    end else begin
      logic set_t;
      set_t = 0;
      case (ph)
        0: if (bus_wr && !m_prev && !dir && !pwait) begin
             ph = 1; rem = SU; m_dat = din; m_sel = sel;
           end
        1: begin rem--; if (rem == 0) begin ph = 2; rem = TM; end end
        2: if (pwait) ph = 3;
           else begin rem--; if (rem == 0) begin ph = 3; set_t = 1; end end
        3: if (!bus_wr) begin ph = 4; rem = HD; end
        default: begin rem--; if (rem == 0) ph = 0; end
      endcase
      if (set_t) m_tmo = 1;
      else if (clr) m_tmo = 0;
      m_prev = bus_wr;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic e_stb;
    e_stb = (ph == 2 || ph == 3);
    chk(wr_n === (ph == 0), "R2/R6 write_no", wr_n, ph == 0);
    chk(pd_oe === (ph != 0), "R2/R6 oe", pd_oe, ph != 0);
    chk(ds_n === !(e_stb && !m_sel), "R4 data_stb", ds_n, !(e_stb && !m_sel));
    chk(as_n === !(e_stb && m_sel), "R4 addr_stb", as_n, !(e_stb && m_sel));
    chk(rdy === !(ph == 1 || ph == 2), "R5 ready", rdy, !(ph == 1 || ph == 2));
    chk(pd === m_dat, "R3 data", pd, m_dat);
    chk(tmo === m_tmo, "R8 tmo", tmo, m_tmo);
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // host write with peripheral answering `dly` cycles after strobe (negative: never)
  task automatic host_wr(input logic s, input logic [DW-1:0] d, input int dly);
    sel = s; din = d; bus_wr = 1; step();
    for (int i = 0; i < 40 && ds_n && as_n; i++) step();
    if (dly >= 0) begin step(dly); pwait = 1; end
    for (int i = 0; i < 40 && !rdy; i++) step();
    step(); bus_wr = 0;
    for (int i = 0; i < 40 && !(ds_n && as_n); i++) step();
    pwait = 0;
    for (int i = 0; i < 40 && !wr_n; i++) step();
    step();
  endtask

  initial begin
    step(3);
    #0;
    chk(wr_n && ds_n && as_n && rdy && !pd_oe && pd == 0 && !tmo, "R10 reset", {wr_n, ds_n, as_n, rdy, pd_oe, tmo}, 6'b111100);
    rst_n = 1; step(2);

    host_wr(0, 8'hA5, 3);                                  // R2 R3 R5 R6 data register
    chk(pd == 8'hA5, "R2 captured byte", pd, 8'hA5);
    host_wr(1, 8'h3C, 0);                                  // R4 address register
    chk(pd == 8'h3C, "R4 addr byte", pd, 8'h3C);

    dir = 1; sel = 0; din = 8'h11; bus_wr = 1; step(4);    // R1
    chk(wr_n && ds_n && as_n && rdy && !pd_oe, "R1 dir blocks", wr_n, 1);
    bus_wr = 0; dir = 0; step(2);

    pwait = 1; din = 8'h22; bus_wr = 1; step(4);           // R9 wait high in idle
    chk(wr_n && rdy, "R9 wait high drops edge", wr_n, 1);
    bus_wr = 0; pwait = 0; step(2);

    host_wr(0, 8'h5A, -1);                                 // R7 timeout
    chk(tmo === 1'b1, "R7 timeout flag", tmo, 1);
    step(3);
    chk(tmo === 1'b1, "R8 sticky", tmo, 1);
    clr = 1; step(); clr = 0; step();
    chk(tmo === 1'b0, "R8 cleared", tmo, 0);

    host_wr(1, 8'h77, TM - 1);                             // R5 answer at last strobe cycle
    chk(tmo === 1'b0, "R7 boundary no timeout", tmo, 0);

    // R9 edge during release is dropped
    sel = 0; din = 8'h99; bus_wr = 1; step();
    for (int i = 0; i < 40 && ds_n; i++) step();
    pwait = 1; step(); bus_wr = 0; step(2);
    bus_wr = 1; pwait = 0; step(HD + 3);
    chk(wr_n === 1'b1, "R9 busy edge dropped", wr_n, 1);
    bus_wr = 0; step(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule